// File: doc/BRIEF.md
# DMA Byte-Lane FIFO Port

This block joins a 16-bit DMA data bus to a byte-wide transfer FIFO inside a storage-bus controller. A two-bit lane-select input picks one of three transfer widths on the bus: the low byte alone, the high byte alone, or the whole word. One code is reserved. Each byte lane carries its own odd-parity bit. Parity is checked on data written into the FIFO and generated on data read out of it. A DMA request output is computed from FIFO occupancy. What it tests depends on the transfer direction and on whether the DMA engine moves bytes or words.

The opposite side of the FIFO faces the controller's core through two byte streams with valid/ready handshakes. In the memory-bound direction the core pushes bytes in and the DMA bus reads them out. In the device-bound direction the DMA bus writes and the core pops. A push completes in a cycle where `core_in_valid` and `core_in_ready` are both high. A pop completes in a cycle where `core_out_valid` and `core_out_ready` are both high. The core must hold valid and data steady while it is stalled. Ready may drop at any time, and that back-pressures the core. An active-low acknowledge grants the bus access to the FIFO. A chip-select that is also low marks a protocol violation.

Top module: `dma_lane_port`

## Requirements
- R1: Lane select 2'b00 moves one byte on bits 7:0. 2'b11 moves one byte on bits 15:8. 2'b10 moves a word, with bits 7:0 as the earlier FIFO byte and bits 15:8 as the later one.
- R2: A bus access with lane select 2'b01 moves no data, leaves the FIFO contents unchanged and leaves `bus_rdata`/`bus_rpar` unchanged.
- R3: `bus_rdata` and `bus_rpar` update one cycle after an accepted read. `bus_rpar[1]` makes `bus_rdata[15:8]` plus itself odd, and `bus_rpar[0]` does the same for bits 7:0. An undriven lane reads as 8'h00 with parity 1.
- R4: An accepted write whose parity mismatches on an enabled lane sets sticky `par_err` on the next cycle. A mismatch on a disabled lane, or on a reserved-code access, is ignored.
- R5: In the memory-bound direction (`dir_to_mem`=1), `dreq` is high exactly when the FIFO holds at least one unit. A unit is 1 byte when `byte_mode`=1 and 2 bytes otherwise.
- R6: In the device-bound direction, `dreq` is high exactly when the FIFO has room for at least one unit.
- R7: When `dma_active` is low, `dreq` is high impedance and bus accesses are ignored.
- R8: A bus access happens only when `bus_strobe` is high, `dack_n` is low and `cs_n` is high. If `dack_n` and `cs_n` are low together, the access is ignored and sticky `proto_err` sets.
- R9: A read that asks for more bytes than the FIFO holds, or a write that needs more room than it has, is ignored entirely. The FIFO never overflows and never underflows.
- R10: `core_in_ready` is high only in the memory-bound direction while the FIFO is not full. `core_out_valid` is high only in the device-bound direction while the FIFO is not empty. Bytes leave in the order they entered.
- R11: After reset the FIFO is empty, `bus_rdata` is 0, `bus_rpar` is 2'b11, and both error flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_active | input | 1 | A DMA operation is in progress |
| dir_to_mem | input | 1 | 1: FIFO to memory (bus reads), 0: memory to FIFO (bus writes) |
| byte_mode | input | 1 | Request granularity: 1 byte when high, 2 bytes when low |
| lane_sel | input | 2 | Lane select: 00 low byte, 11 high byte, 10 word, 01 reserved |
| dack_n | input | 1 | Active-low DMA acknowledge, grants FIFO access |
| cs_n | input | 1 | Active-low register chip select |
| bus_strobe | input | 1 | One bus transfer in this cycle |
| bus_wdata | input | 16 | Bus write data |
| bus_wpar | input | 2 | Bus write parity, bit 1 for the high lane |
| bus_rdata | output | 16 | Bus read data (registered) |
| bus_rpar | output | 2 | Bus read parity (registered) |
| dreq | output | 1 | DMA request, high impedance when idle |
| core_in_valid | input | 1 | Core byte offered to the FIFO |
| core_in_ready | output | 1 | FIFO accepts a core byte |
| core_in_data | input | 8 | Core byte into the FIFO |
| core_out_valid | output | 1 | FIFO byte offered to the core |
| core_out_ready | input | 1 | Core takes the FIFO byte |
| core_out_data | output | 8 | FIFO byte to the core |
| par_err | output | 1 | Sticky incoming parity error |
| proto_err | output | 1 | Sticky acknowledge/chip-select overlap |

## Verification
The hardest states to reach are the ones where byte and word granularity disagree: one byte of data or one byte of room left in the FIFO. Here `dreq` must differ between the two modes, and a word access must be refused while a byte access still succeeds. The bench reaches them by filling the FIFO with single-byte lane writes up to 15 bytes. In the other direction it pushes an odd count of core bytes and reads them off in words. At each point it toggles `byte_mode` and probes with both access widths. A second sweep crosses every lane code with every parity-corruption mask. It orders the cases so that all the combinations that must be ignored run before the first one that must set the sticky flag.

// File: rtl/dma_lane_pkg.sv
package dma_lane_pkg;

  typedef enum logic [1:0] {
    SEL_LOWER = 2'b00,
    SEL_RSVD  = 2'b01,
    SEL_WORD  = 2'b10,
    SEL_UPPER = 2'b11
  } lane_sel_e;

  localparam int LANES  = 2;
  localparam int LANE_W = 8;

  // Parity bit that makes the byte plus the bit contain an odd number of ones.
  function automatic logic odd_par(input logic [LANE_W-1:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/dlp_lane_steer.sv
module dlp_lane_steer
  import dma_lane_pkg::*;
(
  input  logic [1:0]               sel,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic [LANES-1:0]         wpar,
  input  logic [LANE_W-1:0]        head0,
  input  logic [LANE_W-1:0]        head1,
  output logic [1:0]               n_bytes,
  output logic [LANE_W-1:0]        push_b0,
  output logic [LANE_W-1:0]        push_b1,
  output logic                     par_bad,
  output logic [LANES*LANE_W-1:0]  rd_word,
  output logic [LANES-1:0]         rd_par
);

  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] lane_bad;

  always_comb begin
    n_bytes = 2'd0;
    lane_en = '0;
    push_b0 = '0;
    push_b1 = '0;
    rd_word = '0;
    unique case (lane_sel_e'(sel))
      SEL_LOWER: begin
        n_bytes = 2'd1;
        lane_en = 2'b01;
        push_b0 = wdata[LANE_W-1:0];
        rd_word = {{LANE_W{1'b0}}, head0};
      end
      SEL_UPPER: begin
        n_bytes = 2'd1;
        lane_en = 2'b10;
        push_b0 = wdata[2*LANE_W-1:LANE_W];
        rd_word = {head0, {LANE_W{1'b0}}};
      end
      SEL_WORD: begin
        n_bytes = 2'd2;
        lane_en = 2'b11;
        push_b0 = wdata[LANE_W-1:0];
        push_b1 = wdata[2*LANE_W-1:LANE_W];
        rd_word = {head1, head0};
      end
      default: begin
        n_bytes = 2'd0;
      end
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bad[g] = lane_en[g] && (odd_par(wdata[g*LANE_W +: LANE_W]) != wpar[g]);
    assign rd_par[g]   = odd_par(rd_word[g*LANE_W +: LANE_W]);
  end

  assign par_bad = |lane_bad;

endmodule

// File: rtl/dlp_byte_fifo.sv
module dlp_byte_fifo #(
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       push_n,
  input  logic [7:0]       push_b0,
  input  logic [7:0]       push_b1,
  input  logic [1:0]       pop_n,
  output logic [CNT_W-1:0] count,
  output logic [7:0]       head0,
  output logic [7:0]       head1
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [PTR_W-1:0] wp1, rp1;

  assign wp1   = wp + PTR_W'(1);
  assign rp1   = rp + PTR_W'(1);
  assign head0 = mem[rp];
  assign head1 = mem[rp1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (push_n != 2'd0) mem[wp]  <= push_b0;
      if (push_n == 2'd2) mem[wp1] <= push_b1;
      wp    <= wp + PTR_W'(push_n);
      rp    <= rp + PTR_W'(pop_n);
      count <= count + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  // Occupancy bounds guarded against the requests arriving from the port logic.
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(count) + int'(push_n) - int'(pop_n)) <= DEPTH);

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(count));

endmodule

// File: rtl/dlp_dreq_gen.sv
module dlp_dreq_gen #(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] count,
  input  logic             dir_to_mem,
  input  logic             byte_mode,
  output logic             req
);

  logic [CNT_W-1:0] unit;
  logic [CNT_W-1:0] room;

  assign unit = byte_mode ? CNT_W'(1) : CNT_W'(2);
  assign room = CNT_W'(DEPTH) - count;
  assign req  = dir_to_mem ? (count >= unit) : (room >= unit);

endmodule

// File: rtl/dma_lane_port.sv
module dma_lane_port
  import dma_lane_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dma_active,
  input  logic        dir_to_mem,
  input  logic        byte_mode,
  input  logic [1:0]  lane_sel,
  input  logic        dack_n,
  input  logic        cs_n,
  input  logic        bus_strobe,
  input  logic [15:0] bus_wdata,
  input  logic [1:0]  bus_wpar,
  output logic [15:0] bus_rdata,
  output logic [1:0]  bus_rpar,
  output logic        dreq,
  input  logic        core_in_valid,
  output logic        core_in_ready,
  input  logic [7:0]  core_in_data,
  output logic        core_out_valid,
  input  logic        core_out_ready,
  output logic [7:0]  core_out_data,
  output logic        par_err,
  output logic        proto_err
);

  logic [CNT_W-1:0] count;
  logic [7:0]       head0, head1;
  logic [1:0]       n_bytes;
  logic [7:0]       st_b0, st_b1;
  logic             st_par_bad;
  logic [15:0]      st_rd_word;
  logic [1:0]       st_rd_par;
  logic             bus_ok, rd_ok, wr_ok;
  logic             core_push, core_pop;
  logic             overlap;
  logic [1:0]       push_n, pop_n;
  logic [7:0]       push_b0, push_b1;
  logic             req_raw;

  dlp_lane_steer u_steer (
    .sel     (lane_sel),
    .wdata   (bus_wdata),
    .wpar    (bus_wpar),
    .head0   (head0),
    .head1   (head1),
    .n_bytes (n_bytes),
    .push_b0 (st_b0),
    .push_b1 (st_b1),
    .par_bad (st_par_bad),
    .rd_word (st_rd_word),
    .rd_par  (st_rd_par)
  );

  // Access qualification: acknowledge alone opens the FIFO.
  assign overlap = !dack_n && !cs_n;
  assign bus_ok  = bus_strobe && dma_active && !dack_n && cs_n && (n_bytes != 2'd0);
  assign rd_ok   = bus_ok && dir_to_mem  && (count >= CNT_W'(n_bytes));
  assign wr_ok   = bus_ok && !dir_to_mem && ((CNT_W'(DEPTH) - count) >= CNT_W'(n_bytes));

  // Core streams, one per direction.
  assign core_in_ready  = dir_to_mem && (count != CNT_W'(DEPTH));
  assign core_push      = core_in_valid && core_in_ready;
  assign core_out_valid = !dir_to_mem && (count != '0);
  assign core_out_data  = head0;
  assign core_pop       = core_out_valid && core_out_ready;

  always_comb begin
    push_n  = 2'd0;
    push_b0 = core_in_data;
    push_b1 = '0;
    if (wr_ok) begin
      push_n  = n_bytes;
      push_b0 = st_b0;
      push_b1 = st_b1;
    end else if (core_push) begin
      push_n = 2'd1;
    end
  end

  always_comb begin
    pop_n = 2'd0;
    if (rd_ok)         pop_n = n_bytes;
    else if (core_pop) pop_n = 2'd1;
  end

  dlp_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_n  (push_n),
    .push_b0 (push_b0),
    .push_b1 (push_b1),
    .pop_n   (pop_n),
    .count   (count),
    .head0   (head0),
    .head1   (head1)
  );

  dlp_dreq_gen #(.DEPTH(DEPTH)) u_dreq (
    .count      (count),
    .dir_to_mem (dir_to_mem),
    .byte_mode  (byte_mode),
    .req        (req_raw)
  );

  assign dreq = dma_active ? req_raw : 1'bz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_rpar  <= 2'b11;
      par_err   <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      if (rd_ok) begin
        bus_rdata <= st_rd_word;
        bus_rpar  <= st_rd_par;
      end
      if (wr_ok && st_par_bad) par_err <= 1'b1;
      if (overlap) proto_err <= 1'b1;
    end
  end

  assert_rsvd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && lane_sel == 2'b01 && !core_push && !core_pop) |=> $stable(count));

  assert_overlap_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (overlap && !core_push && !core_pop) |=> ($stable(count) && $stable(bus_rdata)));

  assert_proto_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  assert_par_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err);

  assert_one_pusher_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && core_push) && !(rd_ok && core_pop));

endmodule

// File: tb/tb_dma_lane_port.sv
module tb_dma_lane_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dma_active = 1'b0, dir_to_mem = 1'b0, byte_mode = 1'b0;
  logic [1:0]  lane_sel = 2'b00;
  logic        dack_n = 1'b1, cs_n = 1'b1, bus_strobe = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  bus_wpar = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  bus_rpar;
  wire         dreq;
  logic        core_in_valid = 1'b0, core_in_ready;
  logic [7:0]  core_in_data = '0;
  logic        core_out_valid, core_out_ready = 1'b0;
  logic [7:0]  core_out_data;
  logic        par_err, proto_err;

  int checks = 0;
  int fails = 0;
  logic [7:0]  q[$];
  logic [15:0] erd = '0;
  logic [1:0]  erp = 2'b11;
  logic        epe = 1'b0, epr = 1'b0;

  always #4 clk = ~clk;

  dma_lane_port dut (.*);

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [1:0] gp(input logic [15:0] d);
    return {~^d[15:8], ~^d[7:0]};
  endfunction

  function automatic logic exp_dreq();
    int u;
    if (!dma_active) return 1'bz;
    u = byte_mode ? 1 : 2;
    if (dir_to_mem) return q.size() >= u;
    return (16 - q.size()) >= u;
  endfunction

  task automatic chk_dreq(input string r);
    logic e;
    #1;
    e = exp_dreq();
    checks++;
    if (dreq !== e) begin
      fails++;
      $display("FAIL %s dreq actual=%b expected=%b", r, dreq, e);
    end
  endtask

  // One bus access; the model applies the acceptance rules of R1, R2, R7, R8, R9.
  task automatic bus_acc(input logic [1:0] sel, input logic [15:0] d, input logic [1:0] p,
                         input logic dk, input logic cs, input string r);
    int n;
    bit bad;
    n = (sel == 2'b10) ? 2 : (sel == 2'b01) ? 0 : 1;
    lane_sel = sel; bus_wdata = d; bus_wpar = p;
    dack_n = dk; cs_n = cs; bus_strobe = 1'b1;
    tick();
    bus_strobe = 1'b0; dack_n = 1'b1; cs_n = 1'b1;
    if (!dk && !cs) epr = 1'b1;
    if (dma_active && !dk && cs && n != 0) begin
      if (dir_to_mem) begin
        if (q.size() >= n) begin
          if (sel == 2'b10) erd = {q[1], q[0]};
          else if (sel == 2'b11) erd = {q[0], 8'h00};
          else erd = {8'h00, q[0]};
          erp = gp(erd);
          for (int i = 0; i < n; i++) void'(q.pop_front());
        end
      end else if (16 - q.size() >= n) begin
        bad = 1'b0;
        if (sel != 2'b11 && p[0] != gp(d)[0]) bad = 1'b1;
        if (sel != 2'b00 && p[1] != gp(d)[1]) bad = 1'b1;
        if (bad) epe = 1'b1;
        if (sel == 2'b11) q.push_back(d[15:8]);
        else q.push_back(d[7:0]);
        if (sel == 2'b10) q.push_back(d[15:8]);
      end
    end
    chk({r, " rdata"}, {16'h0, bus_rdata}, {16'h0, erd});
    chk({r, " rpar"}, {30'h0, bus_rpar}, {30'h0, erp});
    chk({r, " par_err"}, {31'h0, par_err}, {31'h0, epe});
    chk({r, " proto_err"}, {31'h0, proto_err}, {31'h0, epr});
  endtask

  task automatic core_push(input logic [7:0] b, input string r);
    logic er;
    core_in_valid = 1'b1; core_in_data = b;
    #1;
    er = dir_to_mem && q.size() < 16;
    chk({r, " core_in_ready"}, {31'h0, core_in_ready}, {31'h0, er});
    tick();
    core_in_valid = 1'b0;
    if (er) q.push_back(b);
  endtask

  task automatic core_pop(input string r);
    logic ev;
    ev = !dir_to_mem && q.size() > 0;
    chk({r, " core_out_valid"}, {31'h0, core_out_valid}, {31'h0, ev});
    if (ev) chk({r, " core_out_data"}, {24'h0, core_out_data}, {24'h0, q[0]});
    core_out_ready = 1'b1;
    tick();
    core_out_ready = 1'b0;
    if (ev) void'(q.pop_front());
  endtask

  task automatic drain_core(input string r);
    while (q.size() > 0) begin
      core_pop(r);
      chk_dreq("R6");
    end
    core_pop(r);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state, R7 idle request
    chk("R11 rdata", {16'h0, bus_rdata}, 32'h0);
    chk("R11 rpar", {30'h0, bus_rpar}, 32'h3);
    chk("R11 par_err", {31'h0, par_err}, 32'h0);
    chk("R11 proto_err", {31'h0, proto_err}, 32'h0);
    chk("R11 core_out_valid", {31'h0, core_out_valid}, 32'h0);
    chk_dreq("R7 idle");

    // Device-bound word fill to overflow (R6, R9), then drain in order (R1, R10)
    dma_active = 1'b1; dir_to_mem = 1'b0; byte_mode = 1'b0;
    for (int i = 0; i < 10; i++) begin
      logic [15:0] d;
      d = {8'(i * 29 + 3), 8'(i * 17 + 1)};
      bus_acc(2'b10, d, gp(d), 1'b0, 1'b1, "R9 word fill");
      chk_dreq("R6 word");
    end
    byte_mode = 1'b1;
    chk_dreq("R6 full byte");
    byte_mode = 1'b0;
    drain_core("R10 drain");

    // Lane sweep with good parity, reserved code included (R1, R2)
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 3; v++) begin
        logic [15:0] d;
        d = {8'(s * 64 + v * 7 + 5), 8'(v * 37 + s + 9)};
        bus_acc(2'(s), d, gp(d), 1'b0, 1'b1, (s == 1) ? "R2 rsvd write" : "R1 lane write");
      end
    end
    drain_core("R1 lane drain");

    // Parity sweep: every ignorable corruption first, then one real one (R4)
    for (int pass = 0; pass < 2; pass++) begin
      for (int s = 0; s < 4; s++) begin
        for (int m = 1; m < 4; m++) begin
          logic [1:0] en;
          logic [15:0] d;
          en = (s == 0) ? 2'b01 : (s == 3) ? 2'b10 : (s == 2) ? 2'b11 : 2'b00;
          d = {8'(m * 51 + s), 8'(s * 13 + m)};
          if (pass == 0 && (en & 2'(m)) == 2'b00)
            bus_acc(2'(s), d, gp(d) ^ 2'(m), 1'b0, 1'b1, "R4 ignored parity");
          if (pass == 1 && s == 3 && m == 2)
            bus_acc(2'(s), d, gp(d) ^ 2'(m), 1'b0, 1'b1, "R4 bad parity");
        end
      end
      drain_core("R4 drain");
    end

    // One byte of room: byte and word modes disagree (R6, R9)
    for (int i = 0; i < 15; i++) bus_acc(2'b00, 16'(i * 3 + 1), gp(16'(i * 3 + 1)), 1'b0, 1'b1, "R6 byte fill");
    byte_mode = 1'b0; chk_dreq("R6 room1 word");
    byte_mode = 1'b1; chk_dreq("R6 room1 byte");
    bus_acc(2'b10, 16'hA55A, gp(16'hA55A), 1'b0, 1'b1, "R9 word refused");
    bus_acc(2'b11, 16'hC300, gp(16'hC300), 1'b0, 1'b1, "R1 last byte upper");
    chk_dreq("R6 full");
    drain_core("R9 drain");

    // Memory-bound: core pushes, bus reads (R1, R3, R5, R2, R9)
    dir_to_mem = 1'b1; byte_mode = 1'b0;
    chk_dreq("R5 empty");
    for (int i = 0; i < 5; i++) core_push(8'(i * 41 + 7), "R10 push");
    bus_acc(2'b10, 16'h0, 2'b00, 1'b0, 1'b1, "R3 word read");
    bus_acc(2'b11, 16'h0, 2'b00, 1'b0, 1'b1, "R3 upper read");
    bus_acc(2'b01, 16'h0, 2'b00, 1'b0, 1'b1, "R2 rsvd read");
    bus_acc(2'b00, 16'h0, 2'b00, 1'b0, 1'b1, "R3 lower read");
    chk_dreq("R5 one byte word");
    byte_mode = 1'b1; chk_dreq("R5 one byte byte");
    bus_acc(2'b10, 16'h0, 2'b00, 1'b0, 1'b1, "R9 word underflow");
    bus_acc(2'b11, 16'h0, 2'b00, 1'b0, 1'b1, "R3 last upper");
    chk_dreq("R5 empty byte");
    bus_acc(2'b00, 16'h0, 2'b00, 1'b0, 1'b1, "R9 empty read");

    // Fill through the core until back-pressure, then word reads (R10, R1)
    for (int i = 0; i < 17; i++) core_push(8'(255 - i * 11), "R10 fill");
    chk_dreq("R5 full");
    core_pop("R10 no out");
    for (int i = 0; i < 8; i++) begin
      bus_acc(2'b10, 16'h0, 2'b00, 1'b0, 1'b1, "R1 word drain");
      chk_dreq("R5 drain");
    end

    // Acknowledge with chip select (R8), chip select alone, then idle (R7)
    core_push(8'h3C, "R8 setup");
    bus_acc(2'b00, 16'h0, 2'b00, 1'b1, 1'b0, "R8 cs only");
    bus_acc(2'b00, 16'h0, 2'b00, 1'b0, 1'b0, "R8 overlap");
    dma_active = 1'b0;
    chk_dreq("R7 idle dreq");
    bus_acc(2'b00, 16'h0, 2'b00, 1'b0, 1'b1, "R7 idle read");
    dma_active = 1'b1;
    bus_acc(2'b00, 16'h0, 2'b00, 1'b0, 1'b1, "R8 legal read");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule